// File: doc/BRIEF.md
# Quad-Channel Serial Register Loader

This block is the digital front end of a four-channel converter that is programmed over a serial link. Every frame holds a 2-bit channel address followed by an 8-bit value. The block places the value in that channel's staging register. A separate active-low strobe copies all four staging registers into the output registers in a single step, so the channels can change together. The serial clock, serial data and both strobes are asynchronous to the system clock. Each passes through a two-flop synchronizer, and every decision the block makes uses the synchronized levels and edges.

The block supports two framings. In three-wire mode, holding the load strobe low commits the most recent ten shifted bits. In two-wire mode, a start condition opens a frame and a stop condition closes it. The start condition is data falling while the clock is high, and it shifts a leading zero. The stop condition is data rising while the clock is high. After reset the block is in two-wire mode. It changes to three-wire mode the first time the load strobe is seen low, and it stays in three-wire mode until the next reset. A serial output takes the bit that leaves the last active shift stage, so several devices can be chained on one data line.

Top module: `quad_serial_loader`

## Requirements
- R1: On every synchronized falling edge of the serial clock, the shift register moves one place and takes in the data level. The bits of a frame arrive first-to-last as A1, A0, D7 … D0. The committed value is therefore the last ten bits shifted: the first two form the address and the next eight form the data, MSB first.
- R2: Address 00 selects channel A, which is output bits [7:0]. Address 01 selects channel B [15:8], 10 selects channel C [23:16] and 11 selects channel D [31:24].
- R3: In three-wire mode, while the load strobe is low, the staging register of the addressed channel takes the committed value. The other channels keep their contents.
- R4: While the load-all strobe is low, every output register copies its staging register. While it is high, the outputs hold their values even when a staging register is written.
- R5: In two-wire mode, a start condition is data falling while the clock is high, followed by a falling clock edge. That edge shifts a 0 and counts as bit one of an 11-bit frame.
- R6: In two-wire mode, a stop condition is data rising while the clock is high. A stop that comes after at least 11 bits have been shifted since the start commits the last ten bits.
- R7: In two-wire mode, a stop that comes after fewer than 11 bits have been shifted since the start drops the frame, and no register is written.
- R8: After reset the block is in two-wire mode. Once the load strobe is seen low, the block is in three-wire mode until reset, and in that mode start and stop conditions commit nothing.
- R9: The registered serial output shows bit 9 of the shift register in three-wire mode, which is the bit shifted ten edges earlier. In two-wire mode it shows bit 10, the bit shifted eleven edges earlier.
- R10: Reset clears all staging and output registers and the serial output to 0.
- R11: In a two-wire cascade frame, two payloads are sent between one start and one stop: start, ten bits, a zero bit, ten bits, stop. Only the second payload is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock, asynchronous; idles high |
| sda_i | input | 1 | Serial data, asynchronous; idles high |
| load_n_i | input | 1 | Active-low load strobe; a low level also selects three-wire mode |
| load_all_n_i | input | 1 | Active-low strobe that copies staging registers to outputs |
| ser_o | output | 1 | Cascade serial output |
| chan_o | output | 32 | Output registers, channel D in the top byte down to channel A in the bottom byte |

## Verification
Two situations are the hardest to reach from the ports. The first is a two-wire cascade frame, where the bit count passes eleven before the stop arrives. The second is a stop that arrives too early. Both are reachable only while the block is still in two-wire mode, because the mode is sticky. For that reason the bench runs every two-wire scenario first, including one that checks the serial output at the start-bit boundary. It then applies reset, drives the load strobe low, and sweeps all 256 data values across the four channels in three-wire mode.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_ARMED = 2'd1,
    FR_BODY  = 2'd2
  } fr_state_t;
endpackage

// File: rtl/qsr_pin_sync.sv
module qsr_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/qsr_framer.sv
module qsr_framer
  import qsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              ld_lvl,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ser_o
);
  localparam int PAY_W = ADDR_W + DATA_W;
  localparam int SR_W  = PAY_W + 1;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SR_W);

  fr_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SR_W-1:0]   sr_q;
  logic              mode3_q;
  logic              commit;
  logic              wr_en_q, ser_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    commit = 1'b0;
    if (mode3_q) begin
      st_d  = FR_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        FR_IDLE: begin
          if (sda_fall && scl_lvl) st_d = FR_ARMED;
        end
        FR_ARMED: begin
          if (scl_fall) begin
            st_d  = FR_BODY;
            cnt_d = CNT_W'(1);
          end else if (sda_rise && scl_lvl) begin
            st_d = FR_IDLE;
          end
        end
        FR_BODY: begin
          if (scl_fall) begin
            if (cnt_q != FULL) cnt_d = cnt_q + CNT_W'(1);
          end else if (sda_fall && scl_lvl) begin
            st_d = FR_ARMED;
          end else if (sda_rise && scl_lvl) begin
            commit = (cnt_q == FULL);
            st_d   = FR_IDLE;
          end
        end
        default: st_d = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= FR_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      mode3_q   <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      ser_q     <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (!ld_lvl) mode3_q <= 1'b1;
      if (scl_fall)
        sr_q <= {sr_q[SR_W-2:0], (st_q == FR_ARMED) ? 1'b0 : sda_lvl};
      wr_en_q   <= ~ld_lvl | commit;
      wr_addr_q <= sr_q[PAY_W-1 -: ADDR_W];
      wr_data_q <= sr_q[DATA_W-1:0];
      ser_q     <= mode3_q ? sr_q[PAY_W-1] : sr_q[SR_W-1];
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign ser_o     = ser_q;

  assert_shift_order_R1: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && st_q != FR_ARMED) |=> (sr_q[0] == $past(sda_lvl)));

  assert_start_opens_R5: assert property (@(posedge clk) disable iff (rst)
    (!mode3_q && st_q == FR_ARMED && scl_fall) |=> (st_q == FR_BODY && cnt_q == CNT_W'(1)));

  assert_short_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode3_q && ld_lvl && st_q == FR_BODY && !scl_fall && !sda_fall && sda_rise && scl_lvl && cnt_q != FULL)
      |=> !wr_en_q);

  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    mode3_q |=> mode3_q);
endmodule

// File: rtl/qsr_regbank.sv
module qsr_regbank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           ld_all_lvl,
  output logic [(1<<ADDR_W)*DATA_W-1:0]  out_o
);
  localparam int NCH = 1 << ADDR_W;

  logic [NCH-1:0][DATA_W-1:0] stage_q;
  logic [NCH-1:0][DATA_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (wr_en) stage_q[wr_addr] <= wr_data;
      if (!ld_all_lvl) out_q <= stage_q;
    end
  end

  assign out_o = out_q;

  assert_stage_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(stage_q));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ld_all_lvl |=> $stable(out_q));
endmodule

// File: rtl/quad_serial_loader.sv
module quad_serial_loader #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          scl_i,
  input  logic                          sda_i,
  input  logic                          load_n_i,
  input  logic                          load_all_n_i,
  output logic                          ser_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0] chan_o
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pins, lvl, rise, fall;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign pins = {load_all_n_i, load_n_i, sda_i, scl_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    qsr_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pins[p]),
      .lvl_o  (lvl[p]),
      .rise_o (rise[p]),
      .fall_o (fall[p])
    );
  end

  qsr_framer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (lvl[0]),
    .scl_fall  (fall[0]),
    .sda_lvl   (lvl[1]),
    .sda_rise  (rise[1]),
    .sda_fall  (fall[1]),
    .ld_lvl    (lvl[2]),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .ser_o     (ser_o)
  );

  qsr_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ld_all_lvl (lvl[3]),
    .out_o      (chan_o)
  );
endmodule

// File: tb/quad_serial_loader_tb.sv
module quad_serial_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int LIMIT      = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1, sda = 1'b1, ld_n = 1'b1, lda_n = 1'b1;
  logic        ser;
  logic [31:0] chan;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] exp_in [4];
  logic [7:0] exp_out[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_serial_loader u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
    .load_n_i(ld_n), .load_all_n_i(lda_n), .ser_o(ser), .chan_o(chan)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 4; i++) chk(req, {24'd0, chan[i*8 +: 8]}, {24'd0, exp_out[i]});
  endtask

  task automatic do_reset();
    rst = 1'b1; scl = 1'b1; sda = 1'b1; ld_n = 1'b1; lda_n = 1'b1;
    wt(5);
    rst = 1'b0;
    wt(5);
    for (int i = 0; i < 4; i++) begin exp_in[i] = 8'd0; exp_out[i] = 8'd0; end
  endtask

  task automatic load_all();
    lda_n = 1'b0; wt(H);
    lda_n = 1'b1; wt(H);
    for (int i = 0; i < 4; i++) exp_out[i] = exp_in[i];
  endtask

  // three-wire bit: data set while clock high, shifted on clock fall
  task automatic bit3(input logic b);
    sda = b; wt(H);
    scl = 1'b0; wt(H);
    scl = 1'b1; wt(H);
  endtask

  task automatic frame3(input logic [9:0] w);
    for (int j = 9; j >= 0; j--) bit3(w[j]);
  endtask

  task automatic load3();
    ld_n = 1'b0; wt(H);
    ld_n = 1'b1; wt(H);
  endtask

  // two-wire bit: data changes only while clock low
  task automatic bit2(input logic b);
    sda = b; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic start2();
    sda = 1'b0; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic stop2();
    sda = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    sda = 1'b1; wt(H);
  endtask

  task automatic frame2(input logic [9:0] w);
    start2();
    for (int j = 9; j >= 0; j--) bit2(w[j]);
    stop2();
  endtask

  initial begin
    logic [9:0] f1, f2;
    do_reset();
    // R10: reset state
    chk_all("R10 reset outputs");
    chk("R10 reset serial out", {31'd0, ser}, 32'd0);

    // two-wire phase (load strobe never low): R2 R5 R6 R8
    for (int k = 0; k < 8; k++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'(k % 4);
      d = 8'(k * 37 + 11);
      frame2({a, d});
      exp_in[a] = d;
      load_all();
      chk_all("R6 R5 R2 two-wire frame commit");
    end

    // R7: stop after only seven bits since start
    start2();
    for (int j = 0; j < 6; j++) bit2(j[0]);
    stop2();
    load_all();
    chk_all("R7 short frame dropped");

    // R4: staging write invisible until load-all
    frame2({2'b00, 8'h5A});
    exp_in[0] = 8'h5A;
    wt(H);
    chk_all("R4 outputs hold without load-all");
    load_all();
    chk_all("R4 load-all copies staging");

    // R11 / R9: cascade frame
    f1 = {2'b10, 8'hC3};
    f2 = {2'b11, 8'h81};
    start2();
    for (int j = 9; j >= 0; j--) bit2(f1[j]);
    chk("R9 two-wire tap shows start bit", {31'd0, ser}, 32'd0);
    bit2(1'b0);
    chk("R9 two-wire tap shows first payload bit", {31'd0, ser}, {31'd0, f1[9]});
    for (int j = 9; j >= 0; j--) bit2(f2[j]);
    stop2();
    exp_in[3] = 8'h81;
    load_all();
    chk_all("R11 cascade commits second payload only");

    // three-wire phase
    do_reset();
    chk_all("R10 reset clears after two-wire use");
    for (int k = 0; k < 256; k++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'(k % 4);
      d = 8'(k) ^ 8'h5A;
      frame3({a, d});
      load3();
      exp_in[a] = d;
      if (k % 4 == 3) begin
        wt(H);
        chk_all("R4 outputs hold before load-all");
        load_all();
        chk_all("R1 R2 R3 three-wire sweep");
      end
    end

    // R9: three-wire tap is ten edges deep
    f1 = {2'b01, 8'hB6};
    f2 = {2'b10, 8'h29};
    frame3(f1);
    for (int j = 0; j < 10; j++) begin
      chk("R9 three-wire serial out", {31'd0, ser}, {31'd0, f1[9-j]});
      bit3(f2[9-j]);
    end

    // R8: start/stop framing ignored once in three-wire mode
    scl = 1'b1; sda = 1'b1; wt(H);
    frame2({2'b00, 8'hEE});
    sda = 1'b1; scl = 1'b1; wt(H);
    load_all();
    chk_all("R8 stop condition ignored in three-wire mode");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule